// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host side of a four-wire serial link to a four-channel bipolar successive-approximation converter. The user hands it a 16-bit control word over a valid/ready request channel. The controller then pulls the active-low select line down to start a conversion and open the frame. It runs sixteen cycles of a divided serial clock, shifting the control word out MSB first and capturing the 16-bit result frame that returns. The returned frame is split into a leading check bit, a 2-bit channel tag, a sign bit and a 12-bit magnitude. These fields are offered on a valid/ready result channel.

The serial clock also paces the conversion inside the converter, so it toggles without a break for the whole frame. It idles high whenever select is high. Between frames, select stays high for one full serial clock period of quiet time. Back-pressure rules: a request is taken on the rising system clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the link is idle, the quiet time has ended and no result is waiting. A result stays on the port, unchanged, from the cycle `res_valid` rises until the edge where `res_ready` is also high. While it waits, no new frame starts.

Top module: `adc_host`

## Requirements
- R1: After reset, `adc_cs_n` = 1, `adc_sclk` = 1, `res_valid` = 0 and `req_ready` = 1.
- R2: While `adc_cs_n` is high, `adc_sclk` is high.
- R3: Each frame holds `adc_cs_n` low for exactly 32·H system clocks and gives exactly 16 rising serial clock edges, where H = `clk_div`+1. The 16th rising edge coincides with `adc_cs_n` returning high.
- R4: After select falls, `adc_sclk` stays high for H system clocks. It then alternates low and high phases of H system clocks each.
- R5: `adc_mosi` carries `req_word` MSB first. Bit 15 is presented from the fall of select, and each following bit is presented at a rising serial clock edge. `adc_mosi` never changes while `adc_sclk` is low, so the converter can take it on each falling edge.
- R6: `adc_miso` is sampled on each of the 16 rising serial clock edges, and the first sample is the frame MSB. The converter presents bit 15 from the fall of select and advances one bit on every falling edge after the first.
- R7: The captured frame is decoded with bit 15 as `res_frame_err` (high means the leading bit was not zero), bits 14:13 as `res_chan`, bit 12 as `res_sign` and bits 11:0 as `res_mag`.
- R8: `res_valid` rises one system clock after select returns high. It stays high with stable fields until taken with `res_ready`, and then falls on the next clock.
- R9: `req_ready` is high only when the link is idle with no result waiting. A frame starts on the clock after an accepted request.
- R10: Between frames, `adc_cs_n` stays high for at least 2·H system clocks, and `req_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Serial half-period minus one, in system clocks; change only while idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_word | input | 16 | Control word to drive toward the converter |
| res_valid | output | 1 | Decoded result available |
| res_ready | input | 1 | Consumer takes the result |
| res_chan | output | 2 | Channel tag from the frame |
| res_sign | output | 1 | Sign bit from the frame |
| res_mag | output | 12 | 12-bit conversion value |
| res_frame_err | output | 1 | Leading frame bit was not zero |
| adc_cs_n | output | 1 | Active-low select / conversion start |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Serial data toward the converter |
| adc_miso | input | 1 | Serial data from the converter |

## Verification
The bench builds the block with DIV_W = 4 and sweeps `clk_div` over 0, 2 and 5. With 0, the serial clock runs at half the system rate and each phase lasts one cycle. The two larger values stretch every phase and the quiet gap over several cycles, so the full half-period and quiet-time arithmetic is exercised. A stalled consumer is used to show that a waiting result blocks the next request. A response whose leading bit is set exercises the frame-error flag.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int FRAME_W = 16;
  localparam int CHAN_W  = 2;
  localparam int MAG_W   = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } link_state_e;

  typedef struct packed {
    logic              err;
    logic [CHAN_W-1:0] chan;
    logic              sign;
    logic [MAG_W-1:0]  mag;
  } frame_fields_t;
endpackage

// File: rtl/adc_host_tick.sv
module adc_host_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R4
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int BITS         = FRAME_W,
  parameter int QUIET_HALVES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic run,
  output logic idle,
  output logic cs_n,
  output logic sclk,
  output logic shift_en,
  output logic frame_done
);
  localparam int BW = $clog2(BITS + 1);
  localparam int QW = $clog2(QUIET_HALVES + 1);

  link_state_e   state;
  logic [BW-1:0] bit_cnt;
  logic [QW-1:0] qcnt;
  logic          last;

  assign run      = (state != ST_IDLE);
  assign idle     = (state == ST_IDLE);
  assign last     = (bit_cnt == BW'(BITS - 1));
  assign shift_en = (state == ST_LOW) && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      bit_cnt    <= '0;
      qcnt       <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= shift_en && last;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LEAD;
          cs_n    <= 1'b0;
          bit_cnt <= '0;
        end
        ST_LEAD: if (tick) begin
          state <= ST_LOW;
          sclk  <= 1'b0;
        end
        ST_LOW: if (tick) begin
          sclk    <= 1'b1;
          bit_cnt <= bit_cnt + 1'b1;
          if (last) begin
            state <= ST_QUIET;
            cs_n  <= 1'b1;
            qcnt  <= '0;
          end else begin
            state <= ST_HIGH;
          end
        end
        ST_HIGH: if (tick) begin
          state <= ST_LOW;
          sclk  <= 1'b0;
        end
        ST_QUIET: if (tick) begin
          if (qcnt == QW'(QUIET_HALVES - 1)) state <= ST_IDLE;
          else                               qcnt  <= qcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R2
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BW'(BITS)); // R3
  AST_DONE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cs_n); // R3
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state == ST_IDLE)); // R9
endmodule

// File: rtl/adc_host_shift.sv
module adc_host_shift #(
  parameter int BITS = adc_host_pkg::FRAME_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_word,
  input  logic            shift_en,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx_word
);
  logic [BITS-1:0] tx;

  assign mosi = tx[BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx      <= '0;
      rx_word <= '0;
    end else begin
      if (load)          tx <= load_word;
      else if (shift_en) tx <= {tx[BITS-2:0], 1'b0};
      if (shift_en)      rx_word <= {rx_word[BITS-2:0], miso};
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift_en |=> $stable(mosi)); // R5
endmodule

// File: rtl/adc_host_decode.sv
module adc_host_decode
  import adc_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               res_ready,
  output logic               res_valid,
  output frame_fields_t      res
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else if (capture) begin
      res_valid <= 1'b1;
      res       <= frame_fields_t'(rx_word);
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res)); // R8
  AST_RESULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !capture |=> !res_valid); // R8
endmodule

// File: rtl/adc_host.sv
module adc_host
  import adc_host_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int QUIET_HALVES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FRAME_W-1:0] req_word,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [CHAN_W-1:0]  res_chan,
  output logic               res_sign,
  output logic [MAG_W-1:0]   res_mag,
  output logic               res_frame_err,
  output logic               adc_cs_n,
  output logic               adc_sclk,
  output logic               adc_mosi,
  input  logic               adc_miso
);
  logic          run, idle, tick, start, shift_en, frame_done;
  logic [FRAME_W-1:0] rx_word;
  frame_fields_t res;

  assign req_ready = idle && !res_valid;
  assign start     = req_valid && req_ready;

  adc_host_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
  );

  adc_host_seq #(.BITS(FRAME_W), .QUIET_HALVES(QUIET_HALVES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .run(run),
    .idle(idle), .cs_n(adc_cs_n), .sclk(adc_sclk), .shift_en(shift_en),
    .frame_done(frame_done)
  );

  adc_host_shift #(.BITS(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_word(req_word),
    .shift_en(shift_en), .miso(adc_miso), .mosi(adc_mosi), .rx_word(rx_word)
  );

  adc_host_decode u_dec (
    .clk(clk), .rst_n(rst_n), .capture(frame_done), .rx_word(rx_word),
    .res_ready(res_ready), .res_valid(res_valid), .res(res)
  );

  assign res_frame_err = res.err;
  assign res_chan      = res.chan;
  assign res_sign      = res.sign;
  assign res_mag       = res.mag;

  AST_MOSI_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_sclk && $past(!adc_sclk) |-> $stable(adc_mosi)); // R5
  AST_READY_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_cs_n && adc_sclk); // R9
  AST_NO_START_WITH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !adc_cs_n && !res_valid); // R9
endmodule

// File: tb/adc_host_test.sv
module adc_host_test;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [15:0]      req_word = '0;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic [1:0]       res_chan;
  logic             res_sign;
  logic [11:0]      res_mag;
  logic             res_frame_err;
  logic             adc_cs_n, adc_sclk, adc_mosi;
  logic             adc_miso = 1'b0;

  always #4 clk = ~clk;

  adc_host #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
    .req_ready(req_ready), .req_word(req_word), .res_valid(res_valid),
    .res_ready(res_ready), .res_chan(res_chan), .res_sign(res_sign),
    .res_mag(res_mag), .res_frame_err(res_frame_err), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(adc_miso)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [15:0] resp_q[$];
  logic [15:0] sent_q[$];
  logic [15:0] expres_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // converter model
  logic [15:0] slv_tx, slv_rx;
  bit          in_frame = 1'b0;
  bit          first_fall;

  always @(negedge adc_cs_n) begin
    if (resp_q.size() > 0) slv_tx = resp_q.pop_front();
    else                   slv_tx = 16'h0;
    adc_miso   = slv_tx[15];
    slv_rx     = '0;
    first_fall = 1'b1;
    in_frame   = 1'b1;
  end

  always @(negedge adc_sclk) begin
    if (in_frame && !adc_cs_n) begin
      slv_rx = {slv_rx[14:0], adc_mosi};
      if (!first_fall) slv_tx = {slv_tx[14:0], 1'b0};
      first_fall = 1'b0;
      adc_miso   = slv_tx[15];
    end
  end

  always @(posedge adc_cs_n) begin
    if (in_frame) begin
      in_frame = 1'b0;
      if (sent_q.size() > 0) begin
        logic [15:0] w;
        w = sent_q.pop_front();
        check(slv_rx == w, "R5", "control word at converter", slv_rx, w);
      end
    end
  end

  // cycle reference model
  int j = -1;
  bit pend_accept = 1'b0;
  bit exp_rv = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int h;
      bit e_cs, e_sclk, e_rdy;
      h = int'(clk_div) + 1;
      if (pend_accept) j = 0;
      else if (j >= 0) j = j + 1;
      if (j == 34 * h) j = -1;
      if (j == 32 * h + 1) exp_rv = 1'b1;
      e_cs   = !(j >= 0 && j < 32 * h);
      e_sclk = (j < h || j >= 32 * h) ? 1'b1 : (((j - h) / h) % 2 == 1);
      e_rdy  = (j < 0) && !exp_rv;
      check(adc_cs_n == e_cs, (j >= 32 * h) ? "R10" : "R3", "select", adc_cs_n, e_cs);
      check(adc_sclk == e_sclk, "R4", "serial clock", adc_sclk, e_sclk);
      check(!adc_cs_n || adc_sclk, "R2", "clock idle high", adc_sclk, 1);
      check(req_ready == e_rdy, "R9", "req_ready", req_ready, e_rdy);
      check(res_valid == exp_rv, "R8", "res_valid", res_valid, exp_rv);
      pend_accept = req_valid && req_ready;
      if (exp_rv && res_valid && res_ready) begin
        logic [15:0] e, a;
        e = (expres_q.size() > 0) ? expres_q.pop_front() : 16'hxxxx;
        a = {res_frame_err, res_chan, res_sign, res_mag};
        check(a == e, "R6", "captured frame", a, e);
        check(res_frame_err == e[15], "R7", "frame error", res_frame_err, e[15]);
        check(res_chan == e[14:13], "R7", "channel", res_chan, e[14:13]);
        check(res_sign == e[12], "R7", "sign", res_sign, e[12]);
        check(res_mag == e[11:0], "R7", "magnitude", res_mag, e[11:0]);
        exp_rv = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      check(1'b0, "WDOG", "watchdog expired", cycles, 150000);
      report();
    end
  end

  task automatic send(input logic [15:0] cmd, input logic [15:0] resp);
    resp_q.push_back(resp);
    sent_q.push_back(cmd);
    expres_q.push_back(resp);
    @(posedge clk); #1;
    req_word  = cmd;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (j < 0 && !exp_rv && !res_valid && expres_q.size() == 0) break;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(adc_cs_n == 1'b1, "R1", "reset select", adc_cs_n, 1);
    check(adc_sclk == 1'b1, "R1", "reset clock", adc_sclk, 1);
    check(res_valid == 1'b0, "R1", "reset valid", res_valid, 0);
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);

    // fastest divider, several channels
    clk_div = 4'd0;
    send(16'h8310, 16'h0A5C);
    send(16'h8350, 16'h3F01);
    send(16'hC0F3, 16'h5800);
    drain();

    // stretched divider
    @(posedge clk); #1 clk_div = 4'd2;
    send(16'h1234, 16'h7FFF);
    send(16'hA5A5, 16'h4001);
    drain();

    // consumer stall blocks the next frame
    @(posedge clk); #1 res_ready = 1'b0;
    send(16'h0F0F, 16'h2ABC);
    repeat (120) @(posedge clk);
    #1 begin
      req_word  = 16'hFFFF;
      req_valid = 1'b1;
    end
    repeat (40) @(negedge clk);
    check(adc_cs_n == 1'b1, "R8", "no frame while result waits", adc_cs_n, 1);
    @(posedge clk); #1 begin
      req_valid = 1'b0;
      res_ready = 1'b1;
    end
    drain();

    // frame error and slowest divider
    @(posedge clk); #1 clk_div = 4'd5;
    send(16'h6001, 16'h8123);
    send(16'h9ABC, 16'h1FFE);
    drain();

    repeat (5) @(posedge clk);
    done = 1'b1;
    report();
  end
endmodule